// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator, (204,188) over GF(256)

This block is the front end of a Reed-Solomon decoder for a shortened code. The code carries 188 payload bytes and 16 parity bytes in a 204-byte block, and it corrects up to eight byte errors. The field is GF(256), generated by x^8 + x^4 + x^3 + x^2 + 1 (0x11D), with alpha = 0x02. The code's generator polynomial has the sixteen consecutive roots alpha^0 to alpha^15.

Bytes arrive one per clock while a valid strobe is high. The first byte of a block is also marked by a start flag. Each of the sixteen accumulators evaluates the received polynomial at its own root by Horner's rule. The byte received first is the highest-order coefficient.

After the last byte of a block is accepted, the sixteen syndromes are presented side by side for one cycle with a done pulse. A flag with them reports that every syndrome is zero, which means no error was detected. The next block may start in the cycle that carries the done pulse, so blocks can follow each other with no gap.

Top module: `rs_syndrome_gen`

## Requirements
- R1: While reset is high and after it is released, out_done, out_syn and out_clean are all zero until the first block completes.
- R2: On completion, out_syn bits [8i+7:8i] hold S_i = XOR over j of r_j·alpha^(i·(203−j)) for i = 0..15. Here r_0 is the first byte accepted, alpha = 0x02, and products are taken modulo 0x11D.
- R3: out_done is high for exactly one cycle. That cycle is the one following the clock edge that accepts the 204th byte of a block.
- R4: out_clean, which changes only with out_done, is 1 exactly when all sixteen presented syndromes are zero. Any valid codeword gives 1, and a single corrupted byte gives 0.
- R5: A byte with in_valid and in_sop both high always starts a new block and discards any partly received block.
- R6: Cycles with in_valid low are skipped whatever in_byte holds, so idle cycles inside a block leave the result unchanged.
- R7: A new block may begin with in_sop in the cycle that carries out_done. Each block is then reported 204 cycles after the previous one.
- R8: Bytes with in_valid high and in_sop low are ignored when no block is open, including after a block has completed. They produce no out_done.
- R9: out_syn and out_clean hold their values between out_done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is present on in_byte |
| in_sop | input | 1 | Marks the first byte of a block (qualified by in_valid) |
| in_byte | input | 8 | Received code byte |
| out_done | output | 1 | One-cycle pulse when the syndromes of a block are ready |
| out_syn | output | 128 | Syndromes S_0..S_15, with S_i at bits [8i+7:8i] |
| out_clean | output | 1 | All sixteen syndromes are zero |

## Verification
The syndromes are tried with several kinds of block:
- An all-zero block and a true codeword built as the product of a random message and the generator polynomial. Both must report clean, and the codeword shows that every root matches the field and the root offset.
- The same codeword with one byte flipped, which must be flagged.
- A block whose only non-zero byte comes last. Every syndrome must then equal that byte, which separates first-byte-high from first-byte-low coefficient order.

Random blocks are also sent:
- With idle cycles carrying junk data inside them.
- After an aborted partial block.
- Back to back.
- Followed by stray unframed bytes.

These show that gating, restart and framing follow the flags.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    localparam int SYM_W    = 8;
    localparam int NUM_SYN  = 16;
    localparam int CW_BYTES = 204;
    // Low byte of the field polynomial x^8+x^4+x^3+x^2+1
    localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic valid;
        logic sop;
        sym_t data;
    } beat_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_OPEN = 1'b1
    } frame_st_e;

    // Multiply by alpha (x) with reduction
    function automatic sym_t gf_xtime(input sym_t a);
        return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_LOW : '0);
    endfunction

    // Generic product; with one constant operand this folds to an XOR net
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t r;
        sym_t s;
        r = '0;
        s = a;
        for (int k = 0; k < SYM_W; k++) begin
            if (b[k]) r = r ^ s;
            s = gf_xtime(s);
        end
        return r;
    endfunction

    function automatic sym_t gf_alpha_pow(input int e);
        sym_t r;
        r = sym_t'(1);
        for (int k = 0; k < e; k++) r = gf_xtime(r);
        return r;
    endfunction

endpackage

// File: rtl/rs_syn_frame.sv
module rs_syn_frame
    import rs_syn_pkg::*;
#(
    parameter int CW_LEN = CW_BYTES
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    output logic  take,
    output logic  clear,
    output logic  last
);
    localparam int CNT_W = $clog2(CW_LEN + 1);

    frame_st_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_now;

    always_comb begin
        clear   = beat.valid && beat.sop;
        take    = beat.valid && (beat.sop || st_q == FR_OPEN);
        cnt_now = beat.sop ? CNT_W'(1) : cnt_q + CNT_W'(1);
        last    = take && (cnt_now == CNT_W'(CW_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
        end else if (take) begin
            if (last) begin
                st_q  <= FR_IDLE;
                cnt_q <= '0;
            end else begin
                st_q  <= FR_OPEN;
                cnt_q <= cnt_now;
            end
        end
    end

endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
    import rs_syn_pkg::*;
#(
    parameter int ROOT_EXP = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic clear,
    input  sym_t din,
    output sym_t acc_next
);
    localparam sym_t ROOT = gf_alpha_pow(ROOT_EXP);

    sym_t acc_q;

    // Horner step; a start byte seeds the accumulator directly
    always_comb begin
        acc_next = clear ? din : (gf_mul(acc_q, ROOT) ^ din);
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (take) acc_q <= acc_next;
    end

endmodule

// File: rtl/rs_syn_latch.sv
module rs_syn_latch
    import rs_syn_pkg::*;
#(
    parameter int NSYN = NUM_SYN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  last,
    input  logic [NSYN*SYM_W-1:0] syn_next,
    output logic                  done,
    output logic [NSYN*SYM_W-1:0] syn,
    output logic                  clean
);
    logic all_zero;

    always_comb all_zero = ~|syn_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            syn   <= '0;
            clean <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                syn   <= syn_next;
                clean <= all_zero;
            end
        end
    end

endmodule

// File: rtl/rs_syndrome_gen.sv
module rs_syndrome_gen
    import rs_syn_pkg::*;
#(
    parameter int NSYN   = NUM_SYN,
    parameter int CW_LEN = CW_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic [SYM_W-1:0]      in_byte,
    output logic                  out_done,
    output logic [NSYN*SYM_W-1:0] out_syn,
    output logic                  out_clean
);
    beat_t                 beat;
    logic                  take;
    logic                  clear;
    logic                  last;
    logic [NSYN*SYM_W-1:0] syn_next;

    always_comb begin
        beat.valid = in_valid;
        beat.sop   = in_sop;
        beat.data  = in_byte;
    end

    rs_syn_frame #(.CW_LEN(CW_LEN)) u_frame (
        .clk  (clk),
        .rst  (rst),
        .beat (beat),
        .take (take),
        .clear(clear),
        .last (last)
    );

    for (genvar gi = 0; gi < NSYN; gi++) begin : g_cell
        rs_syn_cell #(.ROOT_EXP(gi)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .take    (take),
            .clear   (clear),
            .din     (beat.data),
            .acc_next(syn_next[gi*SYM_W +: SYM_W])
        );
    end

    rs_syn_latch #(.NSYN(NSYN)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .last    (last),
        .syn_next(syn_next),
        .done    (out_done),
        .syn     (out_syn),
        .clean   (out_clean)
    );

endmodule

// File: rtl/rs_syndrome_gen_chk.sv
module rs_syndrome_gen_chk #(
    parameter int NSYN   = 16,
    parameter int CW_LEN = 204
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_sop,
    input logic                out_done,
    input logic [NSYN*8-1:0]   out_syn,
    input logic                out_clean
);
    localparam int CW = $clog2(CW_LEN + 1);

    // Independent count of framed bytes, used to predict the done cycle
    logic          open_q;
    logic [CW-1:0] n_q;
    logic          exp_done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            n_q        <= '0;
            exp_done_q <= 1'b0;
        end else begin
            exp_done_q <= 1'b0;
            if (in_valid && in_sop) begin
                if (CW_LEN == 1) begin
                    exp_done_q <= 1'b1;
                    open_q     <= 1'b0;
                    n_q        <= '0;
                end else begin
                    open_q <= 1'b1;
                    n_q    <= CW'(1);
                end
            end else if (in_valid && open_q) begin
                if (n_q == CW'(CW_LEN - 1)) begin
                    exp_done_q <= 1'b1;
                    open_q     <= 1'b0;
                    n_q        <= '0;
                end else begin
                    n_q <= n_q + CW'(1);
                end
            end
        end
    end

    p_done_timing_r3: assert property (@(posedge clk) disable iff (rst)
        out_done == exp_done_q);

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        (out_done && CW_LEN > 1) |=> !out_done);

    p_clean_match_r4: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_clean == (out_syn == '0)));

    p_sop_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && CW_LEN > 1) |=> !out_done);

    p_idle_no_done_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);

    p_hold_syn_r9: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_syn) && $stable(out_clean)));

endmodule

bind rs_syndrome_gen rs_syndrome_gen_chk #(.NSYN(NSYN), .CW_LEN(CW_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .out_done (out_done),
    .out_syn  (out_syn),
    .out_clean(out_clean)
);

// File: tb/rs_syndrome_gen_test.sv
module rs_syndrome_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int L = 204;
    localparam int K = 188;

    typedef logic [7:0] cw_t [L];

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_sop = 1'b0;
    logic [7:0]     in_byte = 8'h00;
    logic           out_done;
    logic [N*8-1:0] out_syn;
    logic           out_clean;

    rs_syndrome_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_byte(in_byte), .out_done(out_done), .out_syn(out_syn),
        .out_clean(out_clean)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_count = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [N*8-1:0] q_syn[$];
    bit             q_clean[$];
    int             q_cyc[$];
    string          q_tag[$];
    logic [N*8-1:0] last_syn = '0;
    bit             last_clean = 1'b0;

    // Log / antilog tables for the bench's own field arithmetic
    logic [7:0] ex [0:254];
    int         lg [0:255];

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return ex[(lg[a] + lg[b]) % 255];
    endfunction

    function automatic logic [N*8-1:0] model(input cw_t cw);
        logic [N*8-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            logic [7:0] s;
            s = 8'h00;
            for (int j = 0; j < L; j++) s = gm(s, ex[i]) ^ cw[j];
            r[i*8 +: 8] = s;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [N*8-1:0] act,
                         input logic [N*8-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one block, optional idle cycles carrying junk data
    task automatic send_cw(input cw_t cw, input bit gaps, input string tag);
        logic [N*8-1:0] s;
        s = model(cw);
        for (int j = 0; j < L; j++) begin
            if (gaps && (j % 3 == 1)) begin
                in_valid = 1'b0; in_sop = 1'b1; in_byte = 8'hA5;
                @(negedge clk);
            end
            in_valid = 1'b1; in_sop = (j == 0); in_byte = cw[j];
            if (j == L - 1) begin
                q_syn.push_back(s);
                q_clean.push_back(s == '0);
                q_cyc.push_back(cyc + 1);
                q_tag.push_back(tag);
            end
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; in_sop = 1'b0; in_byte = 8'h3C;
        repeat (n) @(negedge clk);
    endtask

    // Monitor
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (out_done && prev_done) check(1'b0, "R3 done longer than one cycle", 1, 0);
            if (out_done) begin
                done_count++;
                if (q_syn.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    logic [N*8-1:0] es;
                    bit ec;
                    int ey;
                    string et;
                    es = q_syn.pop_front(); ec = q_clean.pop_front();
                    ey = q_cyc.pop_front(); et = q_tag.pop_front();
                    check(out_syn == es, {"R2 syndromes ", et}, out_syn, es);
                    check(out_clean == ec, {"R4 clean flag ", et}, out_clean, ec);
                    check(cyc == ey, {"R3 done cycle ", et}, cyc, ey);
                    last_syn = es; last_clean = ec;
                end
            end
            prev_done = out_done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    cw_t cw, good;
    logic [7:0] g [0:16];
    logic [7:0] msg [K];

    initial begin
        ex[0] = 8'h01;
        for (int k = 1; k < 255; k++)
            ex[k] = {ex[k-1][6:0], 1'b0} ^ (ex[k-1][7] ? 8'h1D : 8'h00);
        lg[0] = 0;
        for (int k = 0; k < 255; k++) lg[ex[k]] = k;

        // Generator polynomial, index = power of x
        for (int k = 0; k <= 16; k++) g[k] = 8'h00;
        g[0] = 8'h01;
        for (int r = 0; r < 16; r++) begin
            for (int k = 16; k >= 1; k--) g[k] = g[k-1] ^ gm(g[k], ex[r]);
            g[0] = gm(g[0], ex[r]);
        end

        repeat (3) @(negedge clk);
        check(out_done == 0 && out_syn == '0 && out_clean == 0, "R1 in reset",
              {out_done, out_clean, out_syn}, '0);
        rst = 1'b0;
        idle(3);
        check(out_done == 0 && out_syn == '0 && out_clean == 0, "R1 after reset",
              {out_done, out_clean, out_syn}, '0);

        // All-zero block
        for (int j = 0; j < L; j++) cw[j] = 8'h00;
        send_cw(cw, 1'b0, "R4 zero block"); idle(4);

        // True codeword m(x)*g(x), highest power sent first
        for (int a = 0; a < K; a++) msg[a] = 8'($urandom);
        for (int p = 0; p < L; p++) begin
            logic [7:0] c;
            c = 8'h00;
            for (int b = 0; b <= 16; b++)
                if (p - b >= 0 && p - b < K) c = c ^ gm(msg[p-b], g[b]);
            good[L-1-p] = c;
        end
        send_cw(good, 1'b0, "R2 R4 codeword"); idle(4);
        check(out_clean == 1'b1, "R4 codeword clean", out_clean, 1);

        cw = good; cw[77] = cw[77] ^ 8'h40;
        send_cw(cw, 1'b0, "R4 corrupted"); idle(4);
        check(out_clean == 1'b0, "R4 corrupted flagged", out_clean, 0);

        // Only the last byte non-zero: every syndrome equals it
        for (int j = 0; j < L; j++) cw[j] = 8'h00;
        cw[L-1] = 8'h5A;
        send_cw(cw, 1'b0, "R2 last byte"); idle(4);
        check(out_syn == {N{8'h5A}}, "R2 coefficient order", out_syn, {N{8'h5A}});

        // Gaps inside a block
        for (int j = 0; j < L; j++) cw[j] = 8'($urandom);
        send_cw(cw, 1'b1, "R6 gaps"); idle(4);

        // Partial block then restart
        for (int j = 0; j < 60; j++) begin
            in_valid = 1'b1; in_sop = (j == 0); in_byte = 8'($urandom);
            @(negedge clk);
        end
        for (int j = 0; j < L; j++) cw[j] = 8'($urandom);
        send_cw(cw, 1'b0, "R5 restart"); idle(4);

        // Back to back
        for (int t = 0; t < 3; t++) begin
            for (int j = 0; j < L; j++) cw[j] = 8'($urandom);
            send_cw(cw, 1'b0, "R7 back to back");
        end
        idle(4);

        // Stray unframed bytes after completion
        begin
            int dc;
            logic [N*8-1:0] hold;
            dc = done_count;
            hold = out_syn;
            for (int j = 0; j < 300; j++) begin
                in_valid = 1'b1; in_sop = 1'b0; in_byte = 8'($urandom);
                @(negedge clk);
            end
            idle(4);
            check(done_count == dc, "R8 no done from stray bytes", done_count, dc);
            check(out_syn == hold && out_syn == last_syn, "R9 syndromes held", out_syn, last_syn);
            check(out_clean == last_clean, "R9 clean held", out_clean, last_clean);
        end

        check(q_syn.size() == 0, "R3 all blocks reported", q_syn.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule